// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block supplies the two ALU operands to the execute stage of a five-stage, in-order integer pipeline. For each operand it compares the source register number held in the decode/execute latch with the destinations of the two older instructions. One of those instructions sits in the execute/memory latch and the other in the memory/writeback latch. When an older instruction is about to write that register, the operand is replaced with its result. This lets back-to-back dependent instructions run without a stall.

The block also contains the integer register file. The writeback result is written into it, and the decode stage reads its two source values from it. A write that lands in the same cycle as a read of the same register is returned to the reader. An instruction three slots behind its producer therefore picks up the new value directly from the register file and needs no forwarding path. Writes happen only from the writeback slot, in program order.

Top module: `opfwd_unit`

## Requirements
- R1: When the execute/memory slot has write enable high, a nonzero destination equal to an operand's source register, the operand equals the execute/memory result and that operand's select reads 2'b10.
- R2: When only the memory/writeback slot matches (write enable high, nonzero destination equal to the source), the operand equals the writeback result and the select reads 2'b01.
- R3: Each operand is resolved on its own. The select uses one of three codes: 2'b00 for the register-file value, 2'b10 for execute/memory and 2'b01 for memory/writeback. The select never has both bits set.
- R4: When both older slots match the same source register, the execute/memory result wins (select 2'b10).
- R5: A destination of register 0, or a slot whose write enable is low, is never forwarded. The operand is then the register-file value carried in the latch, with select 2'b00.
- R6: A decode-port read of the register being written by writeback in the same cycle returns the new data in that cycle.
- R7: A written value stays readable in later cycles. Writes to register 0 are dropped, and register 0 always reads 0.
- R8: After reset every register reads 0.
- R9: In a chain ADD R1 followed by XOR, SUB and OR that each read R1, every consumer receives the new R1 with no stall. The XOR gets it through execute/memory, the SUB through memory/writeback, and the OR through the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_ra1 | input | RIDX | Decode read address, port 1 |
| id_ra2 | input | RIDX | Decode read address, port 2 |
| id_rv1 | output | XLEN | Decode read data, port 1 (write-before-read) |
| id_rv2 | output | XLEN | Decode read data, port 2 (write-before-read) |
| ex_rs1 | input | RIDX | Source register of operand A in execute |
| ex_rs2 | input | RIDX | Source register of operand B in execute |
| ex_rf_a | input | XLEN | Latched register-file value for operand A |
| ex_rf_b | input | XLEN | Latched register-file value for operand B |
| exm_rd | input | RIDX | Destination in the execute/memory slot |
| exm_we | input | 1 | Write enable in the execute/memory slot |
| exm_res | input | XLEN | Result in the execute/memory slot |
| mwb_rd | input | RIDX | Destination in the memory/writeback slot (also register-file write address) |
| mwb_we | input | 1 | Write enable in the memory/writeback slot (also register-file write enable) |
| mwb_res | input | XLEN | Result in the memory/writeback slot (also register-file write data) |
| op_a | output | XLEN | Resolved operand A |
| op_b | output | XLEN | Resolved operand B |
| sel_a | output | 2 | Operand A source code |
| sel_b | output | 2 | Operand B source code |

## Verification
Operand values, select codes and decode read data are combinational. They are due in the same cycle the inputs are applied. The bench drives inputs just after a rising edge and samples at the following falling edge. A register-file write becomes stored state at the rising edge that ends its cycle. Persistence and register-0 checks therefore read one cycle later, again at the falling edge. The dependent-instruction chain is stepped one cycle per pipeline advance. The bench latches the decode read of the OR itself and presents it to execute in the next cycle, as a real decode/execute latch would.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MWB     = 2'b01,
    SRC_EXM     = 2'b10
  } opsrc_e;

  // Priority resolve: the younger producer (execute/memory) beats the older one.
  function automatic opsrc_e resolve_src(input logic exm_hit, input logic mwb_hit);
    if (exm_hit)      return SRC_EXM;
    else if (mwb_hit) return SRC_MWB;
    else              return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/opfwd_regfile.sv
module opfwd_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic [RIDX-1:0] rd_addr1,
  input  logic [RIDX-1:0] rd_addr2,
  output logic [XLEN-1:0] rd_data1,
  output logic [XLEN-1:0] rd_data2
);

  logic [XLEN-1:0] regs [NREG];
  logic            wr_live;

  // A write to register 0 is dropped everywhere.
  assign wr_live = wr_en && (wr_addr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wr_addr] <= wr_data;
    end
  end

  // Write-before-read: a same-cycle write is returned to the reader.
  function automatic logic [XLEN-1:0] read_port(input logic [RIDX-1:0] a,
                                                input logic            wl,
                                                input logic [RIDX-1:0] wa,
                                                input logic [XLEN-1:0] wd,
                                                input logic [XLEN-1:0] stored);
    if (a == '0)            return '0;
    else if (wl && wa == a) return wd;
    else                    return stored;
  endfunction

  assign rd_data1 = read_port(rd_addr1, wr_live, wr_addr, wr_data, regs[rd_addr1]);
  assign rd_data2 = read_port(rd_addr2, wr_live, wr_addr, wr_data, regs[rd_addr2]);

  p_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && rd_addr1 == wr_addr) |-> (rd_data1 == wr_data));

  p_zero_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr2 == '0) |-> (rd_data2 == '0));

  p_persist_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && $past(wr_addr) != '0 && !wr_en
     && rd_addr1 == $past(wr_addr)) |-> (rd_data1 == $past(wr_data)));

endmodule

// File: rtl/opfwd_select.sv
module opfwd_select
  import opfwd_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] src,
  input  logic [XLEN-1:0] rf_val,
  input  logic [RIDX-1:0] exm_rd,
  input  logic            exm_we,
  input  logic [XLEN-1:0] exm_res,
  input  logic [RIDX-1:0] mwb_rd,
  input  logic            mwb_we,
  input  logic [XLEN-1:0] mwb_res,
  output logic [1:0]      sel,
  output logic [XLEN-1:0] opnd
);

  // Named hit events, visible to the assertions below.
  logic   exm_hit, mwb_hit;
  opsrc_e choice;

  assign exm_hit = exm_we && (exm_rd != '0) && (exm_rd == src);
  assign mwb_hit = mwb_we && (mwb_rd != '0) && (mwb_rd == src);
  assign choice  = resolve_src(exm_hit, mwb_hit);
  assign sel     = choice;

  always_comb begin
    unique case (choice)
      SRC_EXM: opnd = exm_res;
      SRC_MWB: opnd = mwb_res;
      default: opnd = rf_val;
    endcase
  end

  p_exm_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |-> (opnd == exm_res));

  p_mwb_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |-> (opnd == mwb_res));

  p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  p_younger_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exm_we && exm_rd == src && mwb_we && mwb_rd == src && src != '0) |-> (sel == 2'b10));

  p_zero_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == 2'b00 && opnd == rf_val));

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] id_ra1,
  input  logic [RIDX-1:0] id_ra2,
  output logic [XLEN-1:0] id_rv1,
  output logic [XLEN-1:0] id_rv2,
  input  logic [RIDX-1:0] ex_rs1,
  input  logic [RIDX-1:0] ex_rs2,
  input  logic [XLEN-1:0] ex_rf_a,
  input  logic [XLEN-1:0] ex_rf_b,
  input  logic [RIDX-1:0] exm_rd,
  input  logic            exm_we,
  input  logic [XLEN-1:0] exm_res,
  input  logic [RIDX-1:0] mwb_rd,
  input  logic            mwb_we,
  input  logic [XLEN-1:0] mwb_res,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [1:0]      sel_a,
  output logic [1:0]      sel_b
);

  localparam int NOPND = 2;

  logic [RIDX-1:0] src_v  [NOPND];
  logic [XLEN-1:0] rf_v   [NOPND];
  logic [XLEN-1:0] opnd_v [NOPND];
  logic [1:0]      sel_v  [NOPND];

  assign src_v[0] = ex_rs1;
  assign src_v[1] = ex_rs2;
  assign rf_v[0]  = ex_rf_a;
  assign rf_v[1]  = ex_rf_b;

  opfwd_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (mwb_we),
    .wr_addr  (mwb_rd),
    .wr_data  (mwb_res),
    .rd_addr1 (id_ra1),
    .rd_addr2 (id_ra2),
    .rd_data1 (id_rv1),
    .rd_data2 (id_rv2)
  );

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    opfwd_select #(.XLEN(XLEN), .RIDX(RIDX)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_v[g]),
      .rf_val  (rf_v[g]),
      .exm_rd  (exm_rd),
      .exm_we  (exm_we),
      .exm_res (exm_res),
      .mwb_rd  (mwb_rd),
      .mwb_we  (mwb_we),
      .mwb_res (mwb_res),
      .sel     (sel_v[g]),
      .opnd    (opnd_v[g])
    );
  end

  assign op_a  = opnd_v[0];
  assign op_b  = opnd_v[1];
  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];

  // The two operands must not influence each other.
  p_indep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rs1 == ex_rs2 && ex_rf_a == ex_rf_b) |-> (op_a == op_b && sel_a == sel_b));

endmodule

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;

  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam logic [XLEN-1:0] RFA = 32'hAAAA_0001;
  localparam logic [XLEN-1:0] RFB = 32'hBBBB_0002;
  localparam logic [XLEN-1:0] EXV = 32'h0000_E0E0;
  localparam logic [XLEN-1:0] WBV = 32'h0000_F0F0;

  typedef struct packed {
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [4:0] erd;
    logic       ewe;
    logic [4:0] wrd;
    logic       wwe;
    logic [1:0] xsa;
    logic [1:0] xsb;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4,  5'd3,  1'b1, 5'd9,  1'b1, 2'b10, 2'b00},  // R1 operand A
    '{5'd5,  5'd6,  5'd6,  1'b1, 5'd2,  1'b1, 2'b00, 2'b10},  // R1 operand B
    '{5'd7,  5'd8,  5'd1,  1'b1, 5'd7,  1'b1, 2'b01, 2'b00},  // R2 operand A
    '{5'd2,  5'd2,  5'd9,  1'b1, 5'd2,  1'b1, 2'b01, 2'b01},  // R2 both
    '{5'd4,  5'd9,  5'd4,  1'b1, 5'd9,  1'b1, 2'b10, 2'b01},  // R3 mixed
    '{5'd12, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1, 2'b10, 2'b10},  // R4 priority
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},  // R5 reg 0
    '{5'd10, 5'd11, 5'd10, 1'b0, 5'd11, 1'b0, 2'b00, 2'b00},  // R5 we low
    '{5'd13, 5'd13, 5'd13, 1'b0, 5'd13, 1'b1, 2'b01, 2'b01}   // R4 disabled younger
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [RIDX-1:0] id_ra1 = '0, id_ra2 = '0;
  logic [XLEN-1:0] id_rv1, id_rv2;
  logic [RIDX-1:0] ex_rs1 = '0, ex_rs2 = '0;
  logic [XLEN-1:0] ex_rf_a = '0, ex_rf_b = '0;
  logic [RIDX-1:0] exm_rd = '0, mwb_rd = '0;
  logic            exm_we = 1'b0, mwb_we = 1'b0;
  logic [XLEN-1:0] exm_res = '0, mwb_res = '0;
  logic [XLEN-1:0] op_a, op_b;
  logic [1:0]      sel_a, sel_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  opfwd_unit #(.XLEN(XLEN), .NREG(32)) u_opfwd_unit (
    .clk(clk), .rst_n(rst_n),
    .id_ra1(id_ra1), .id_ra2(id_ra2), .id_rv1(id_rv1), .id_rv2(id_rv2),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .exm_rd(exm_rd), .exm_we(exm_we), .exm_res(exm_res),
    .mwb_rd(mwb_rd), .mwb_we(mwb_we), .mwb_res(mwb_res),
    .op_a(op_a), .op_b(op_b), .sel_a(sel_a), .sel_b(sel_b)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Bench's own view of what an operand should be for a given code.
  function automatic logic [XLEN-1:0] expect_opnd(input logic [1:0] code, input logic [XLEN-1:0] rf);
    case (code)
      2'b10:   return EXV;
      2'b01:   return WBV;
      default: return rf;
    endcase
  endfunction

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  task automatic clear_slots();
    exm_we = 1'b0; mwb_we = 1'b0; exm_rd = '0; mwb_rd = '0;
    ex_rs1 = '0; ex_rs2 = '0;
  endtask

  initial begin
    logic [XLEN-1:0] or_latched;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8: reset state
    id_ra1 = 5'd5; id_ra2 = 5'd31;
    @(negedge clk);
    check("R8 reg5 after reset", id_rv1, '0);
    check("R8 reg31 after reset", id_rv2, '0);

    // Vector table: forwarding selection, R1..R5
    next_cycle();
    exm_res = EXV; mwb_res = WBV; ex_rf_a = RFA; ex_rf_b = RFB;
    for (int i = 0; i < NV; i++) begin
      ex_rs1 = VECS[i].rs1; ex_rs2 = VECS[i].rs2;
      exm_rd = VECS[i].erd; exm_we = VECS[i].ewe;
      mwb_rd = VECS[i].wrd; mwb_we = VECS[i].wwe;
      @(negedge clk);
      check($sformatf("R3 vec%0d sel_a", i), {30'd0, sel_a}, {30'd0, VECS[i].xsa});
      check($sformatf("R3 vec%0d sel_b", i), {30'd0, sel_b}, {30'd0, VECS[i].xsb});
      check($sformatf("R1/R2/R4/R5 vec%0d op_a", i), op_a, expect_opnd(VECS[i].xsa, RFA));
      check($sformatf("R1/R2/R4/R5 vec%0d op_b", i), op_b, expect_opnd(VECS[i].xsb, RFB));
      next_cycle();
    end
    clear_slots();

    // R6: same-cycle write then read returns new data
    mwb_we = 1'b1; mwb_rd = 5'd7; mwb_res = 32'h0000_1234;
    id_ra1 = 5'd7; id_ra2 = 5'd7;
    @(negedge clk);
    check("R6 same-cycle read port1", id_rv1, 32'h0000_1234);
    check("R6 same-cycle read port2", id_rv2, 32'h0000_1234);
    next_cycle();
    // R7: persists; write to register 0 dropped
    mwb_rd = 5'd0; mwb_res = 32'hFFFF_FFFF; id_ra2 = 5'd0;
    @(negedge clk);
    check("R7 reg7 persists", id_rv1, 32'h0000_1234);
    check("R7 reg0 during write", id_rv2, '0);
    next_cycle();
    mwb_we = 1'b0;
    @(negedge clk);
    check("R7 reg0 after write", id_rv2, '0);
    next_cycle();

    // R9: ADD R1 ; XOR R4,R5,R1 ; SUB R7,R1,R6 ; OR R9,R8,R1
    // Preload old R1 value.
    mwb_we = 1'b1; mwb_rd = 5'd1; mwb_res = 32'h0000_0055;
    next_cycle();
    mwb_we = 1'b0; mwb_rd = '0;
    next_cycle();
    // ADD in MEM (result 0x100), XOR in EX reading R1 as operand B.
    exm_we = 1'b1; exm_rd = 5'd1; exm_res = 32'h0000_0100;
    ex_rs1 = 5'd5; ex_rs2 = 5'd1; ex_rf_a = 32'h0000_0005; ex_rf_b = 32'h0000_0055;
    @(negedge clk);
    check("R9 XOR op_b via exm", op_b, 32'h0000_0100);
    check("R9 XOR sel_b", {30'd0, sel_b}, 32'd2);
    next_cycle();
    // ADD in WB, XOR in MEM (dest R4), SUB in EX reading R1 as operand A,
    // OR in ID reading R1 from the register file during the write.
    mwb_we = 1'b1; mwb_rd = 5'd1; mwb_res = 32'h0000_0100;
    exm_we = 1'b1; exm_rd = 5'd4; exm_res = 32'h0000_0105;
    ex_rs1 = 5'd1; ex_rs2 = 5'd6; ex_rf_a = 32'h0000_0055; ex_rf_b = 32'h0000_0006;
    id_ra1 = 5'd8; id_ra2 = 5'd1;
    @(negedge clk);
    check("R9 SUB op_a via mwb", op_a, 32'h0000_0100);
    check("R9 SUB sel_a", {30'd0, sel_a}, 32'd1);
    check("R9 OR decode read of R1", id_rv2, 32'h0000_0100);
    or_latched = id_rv2;
    next_cycle();
    // XOR in WB (R4), SUB in MEM (R7), OR in EX: register-file path only.
    mwb_we = 1'b1; mwb_rd = 5'd4; mwb_res = 32'h0000_0105;
    exm_we = 1'b1; exm_rd = 5'd7; exm_res = 32'h0000_00FA;
    ex_rs1 = 5'd8; ex_rs2 = 5'd1; ex_rf_a = '0; ex_rf_b = or_latched;
    @(negedge clk);
    check("R9 OR op_b via register file", op_b, 32'h0000_0100);
    check("R9 OR sel_b", {30'd0, sel_b}, 32'd0);
    next_cycle();
    clear_slots();
    id_ra1 = 5'd1;
    @(negedge clk);
    check("R9 R1 stored", id_rv1, 32'h0000_0100);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule